// File: doc/BRIEF.md
# Four-Sequencer Sample Capture FIFO

This block is the digital back half of a multi-channel analog-to-digital converter. It has four sample sequencers. Each one owns a 16-entry sample FIFO, a packed status word that shows the FIFO pointers and flags, a mux word, a control word and one interrupt line. A single-cycle trigger pulse from a timer pushes one sample into every sequencer that is enabled and whose 4-bit event-select nibble selects the timer source.

No analog model is involved. A 32-bit pseudo-random state supplies the sample values. Each generated sample steps that state once, and the sequencers are served in ascending order. Software uses a simple register port. A read request returns its data one cycle later, and a read of a sequencer's pop location removes the oldest sample from that FIFO.

Top module: `adc_seq_fifo_top`

## Requirements
- R1: After reset:
  - each sequencer status word reads 0x0000_0100 (empty only);
  - the enable, raw, mask, error-flag and event-select registers read 0;
  - all interrupt lines are low.
- R2: On a cycle with `trig` high, sequencer n receives a sample only if both of these hold:
  - bit n of the enable register (offset 0x00) is 1;
  - event-select bits 4n+3..4n (offset 0x14) equal 5.

  Every other sequencer is left unchanged.
- R3: The noise state resets to 0. For each sample it is first updated to state*314159+1 (modulo 2^32). The sample value is 0x200 plus bits 18:16 of the updated state. When several sequencers sample in the same cycle, the state steps once per sampling sequencer, in ascending index order.
- R4: A push into a FIFO that is not full does the following:
  - it stores the sample at the write pointer;
  - it advances the write pointer modulo 16;
  - it clears empty;
  - it sets full when the write pointer then equals the read pointer.

  A push into a full FIFO is dropped and leaves the FIFO unchanged.
- R5: A pop from a FIFO that is not empty does the following:
  - it returns the entry at the read pointer;
  - it advances the read pointer modulo 16;
  - it clears full;
  - it sets empty when the read pointer then equals the write pointer.

  A pop from an empty FIFO returns 0 and moves no pointer.
- R6: The status word of sequencer n (offset 0x4C + 0x20·n) is laid out as follows:
  - bits 3:0 hold the read pointer;
  - bits 7:4 hold the write pointer;
  - bit 8 is the empty flag;
  - bit 12 is the full flag;
  - all other bits read 0.
- R7: `reg_rdata` shows the read value in the cycle after `reg_rd`. The global registers are:
  - 0x00: enable, which keeps 4 bits;
  - 0x04: raw status;
  - 0x08: mask;
  - 0x0C: masked status, which clears raw status on write;
  - 0x10: error flags;
  - 0x14: event select.

  Sequencer n occupies a window at 0x40 + 0x20·n. Unmapped offsets read 0.
- R8: Within a sequencer window:
  - +0x00 is the mux word, which keeps only the bits of 0x33333333 that were written;
  - +0x04 is the control word, which keeps all 32 bits;
  - +0x08 is the FIFO pop;
  - +0x0C is the status word.
- R9: Raw status behaves as follows:
  - raw bit n is set whenever sequencer n receives a sample, including a sample that is dropped;
  - writing 1 to bit n of 0x0C clears raw bit n, but a set in the same cycle wins;
  - reading 0x0C returns raw AND mask;
  - `irq[n]` is high while raw bit n AND mask bit n is set.
- R10: The error-flag register (0x10) records FIFO errors:
  - a dropped push sets bit n (overflow);
  - a pop from an empty FIFO sets bit 4+n (underflow);
  - writing 1 to a bit clears it, and a set in the same cycle wins.
- R11: A pop and a trigger in the same cycle act on the same FIFO as pop-then-push. A trigger in the same cycle as a register write uses the enable and event-select values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Timer trigger pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle after `reg_rd` |
| irq | output | 4 | Per-sequencer interrupt lines |

## Verification
The hardest states to reach from the ports are a FIFO that is full while a pop and a trigger land in the same cycle, and a trigger that coincides with a write to the enable register. The stimulus reaches them in two steps. It first fills one sequencer with triggers while all others are disabled, and pushes past 16 to raise overflow. It then drives the pop read and the trigger pulse in one cycle. A behavioural model built on queues predicts every read value and the interrupt lines on every clock, so the pointer wrap at 16 and the noise chaining across several sequencers in one cycle are checked as well.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // global register offsets
  localparam logic [7:0] OFF_ENABLE = 8'h00;
  localparam logic [7:0] OFF_RAW    = 8'h04;
  localparam logic [7:0] OFF_MASK   = 8'h08;
  localparam logic [7:0] OFF_MSTAT  = 8'h0C;
  localparam logic [7:0] OFF_ERR    = 8'h10;
  localparam logic [7:0] OFF_EVSEL  = 8'h14;
  // sequencer windows
  localparam logic [7:0] WIN_BASE   = 8'h40;
  localparam int         WIN_LG     = 5;
  localparam logic [4:0] WOFF_MUX   = 5'h00;
  localparam logic [4:0] WOFF_CTL   = 5'h04;
  localparam logic [4:0] WOFF_POP   = 5'h08;
  localparam logic [4:0] WOFF_STAT  = 5'h0C;
  localparam logic [31:0] MUX_KEEP  = 32'h3333_3333;
  // event select code for the timer source
  localparam logic [3:0] EV_TIMER   = 4'h5;
  // status word layout
  localparam int STAT_WR_LSB   = 4;
  localparam int STAT_EMPTY    = 8;
  localparam int STAT_FULL     = 12;
  // noise generator
  localparam logic [31:0] NOISE_MUL  = 32'd314159;
  localparam logic [31:0] NOISE_INC  = 32'd1;
  localparam int          SAMPLE_BASE = 'h200;
  localparam int          NOISE_LSB  = 16;
  localparam int          NOISE_BITS = 3;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo
  import adc_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [31:0]       status,
  output logic              overflow,
  output logic              underflow
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, rd_d, wr_q, wr_d;
  logic              empty_q, empty_d, full_q, full_d;
  logic              do_pop, do_push;

  // pop is applied before push in the same cycle
  assign do_pop  = pop & ~empty_q;
  assign do_push = push & (~full_q | do_pop);

  always_comb begin
    rd_d    = rd_q;
    wr_d    = wr_q;
    empty_d = empty_q;
    full_d  = full_q;
    if (do_pop) rd_d = rd_q + 1'b1;
    if (do_push) wr_d = wr_q + 1'b1;
    if (do_push && !do_pop) begin
      empty_d = 1'b0;
      full_d  = (wr_d == rd_d);
    end else if (do_pop && !do_push) begin
      full_d  = 1'b0;
      empty_d = (rd_d == wr_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      empty_q <= 1'b1;
      full_q  <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      empty_q <= empty_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  assign pop_data  = empty_q ? '0 : mem_q[rd_q];
  assign overflow  = push & ~do_push;
  assign underflow = pop & empty_q;

  always_comb begin
    status = '0;
    status[PTR_W-1:0]               = rd_q;
    status[STAT_WR_LSB +: PTR_W]    = wr_q;
    status[STAT_EMPTY]              = empty_q;
    status[STAT_FULL]               = full_q;
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_q && empty_q)); // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && push && !pop) |=> (full_q && $stable(wr_q))); // R4
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_q && pop && !push) |=> (empty_q && $stable(rd_q))); // R5
endmodule

// File: rtl/adc_seq_noise.sv
module adc_seq_noise
  import adc_seq_pkg::*;
#(
  parameter int NSEQ   = 4,
  parameter int DATA_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NSEQ-1:0]              hit,
  output logic [NSEQ-1:0][DATA_W-1:0]  samples
);
  logic [31:0]          state_q;
  logic [NSEQ:0][31:0]  chain;
  logic                 adv;

  assign chain[0] = state_q;
  assign adv      = |hit;

  // one step per sampling sequencer, ascending index order
  for (genvar k = 0; k < NSEQ; k++) begin : g_step
    assign chain[k+1] = hit[k] ? (chain[k] * NOISE_MUL + NOISE_INC) : chain[k];
    assign samples[k] = DATA_W'(SAMPLE_BASE)
                      + DATA_W'(chain[k+1][NOISE_LSB +: NOISE_BITS]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else if (adv) state_q <= chain[NSEQ];
  end

  AST_NOISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state_q) |-> $past(adv)); // R3
endmodule

// File: rtl/adc_seq_fifo_top.sv
module adc_seq_fifo_top
  import adc_seq_pkg::*;
#(
  parameter int NSEQ   = 4,
  parameter int DEPTH  = 16,
  parameter int DATA_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic [NSEQ-1:0] irq
);
  localparam int EV_W = 4 * NSEQ;

  logic [NSEQ-1:0] enable_q, mask_q, raw_q, raw_d;
  logic [NSEQ-1:0] ovf_q, ovf_d, unf_q, unf_d;
  logic [EV_W-1:0] evsel_q;
  logic [31:0]     rdata_q, rd_val;

  logic sel_en, sel_raw, sel_mask, sel_mst, sel_err, sel_ev;
  logic [NSEQ-1:0] hit, pop, ovf_evt, unf_evt;
  logic [NSEQ-1:0][DATA_W-1:0] samples;
  logic [NSEQ-1:0][31:0]       win_rd;

  assign sel_en   = (reg_addr == OFF_ENABLE);
  assign sel_raw  = (reg_addr == OFF_RAW);
  assign sel_mask = (reg_addr == OFF_MASK);
  assign sel_mst  = (reg_addr == OFF_MSTAT);
  assign sel_err  = (reg_addr == OFF_ERR);
  assign sel_ev   = (reg_addr == OFF_EVSEL);

  adc_seq_noise #(.NSEQ(NSEQ), .DATA_W(DATA_W)) u_noise (
    .clk(clk), .rst_n(rst_n), .hit(hit), .samples(samples));

  for (genvar n = 0; n < NSEQ; n++) begin : g_seq
    localparam logic [7:0] BASE_N = WIN_BASE + 8'(n << WIN_LG);
    logic        win_hit;
    logic [31:0] mux_q, ctl_q, stat;
    logic [DATA_W-1:0] pdata;
    logic        mux_en, ctl_en;

    assign win_hit = (reg_addr[7:WIN_LG] == BASE_N[7:WIN_LG]);
    assign hit[n]  = trig & enable_q[n] & (evsel_q[4*n +: 4] == EV_TIMER);
    assign pop[n]  = reg_rd & win_hit & (reg_addr[WIN_LG-1:0] == WOFF_POP);
    assign mux_en  = reg_wr & win_hit & (reg_addr[WIN_LG-1:0] == WOFF_MUX);
    assign ctl_en  = reg_wr & win_hit & (reg_addr[WIN_LG-1:0] == WOFF_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mux_q <= '0;
        ctl_q <= '0;
      end else begin
        if (mux_en) mux_q <= reg_wdata & MUX_KEEP;
        if (ctl_en) ctl_q <= reg_wdata;
      end
    end

    adc_seq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(hit[n]), .push_data(samples[n]),
      .pop(pop[n]), .pop_data(pdata),
      .status(stat), .overflow(ovf_evt[n]), .underflow(unf_evt[n]));

    always_comb begin
      win_rd[n] = '0;
      if (win_hit) begin
        case (reg_addr[WIN_LG-1:0])
          WOFF_MUX:  win_rd[n] = mux_q;
          WOFF_CTL:  win_rd[n] = ctl_q;
          WOFF_POP:  win_rd[n] = 32'(pdata);
          WOFF_STAT: win_rd[n] = stat;
          default:   win_rd[n] = '0;
        endcase
      end
    end
  end

  // next state of the write-one-to-clear registers; a set wins over a clear
  always_comb begin
    raw_d = raw_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (reg_wr && sel_mst) raw_d = raw_d & ~reg_wdata[NSEQ-1:0];
    if (reg_wr && sel_err) begin
      ovf_d = ovf_d & ~reg_wdata[NSEQ-1:0];
      unf_d = unf_d & ~reg_wdata[4 +: NSEQ];
    end
    raw_d = raw_d | hit;
    ovf_d = ovf_d | ovf_evt;
    unf_d = unf_d | unf_evt;
  end

  always_comb begin
    rd_val = '0;
    if (sel_en)   rd_val = 32'(enable_q);
    if (sel_raw)  rd_val = 32'(raw_q);
    if (sel_mask) rd_val = 32'(mask_q);
    if (sel_mst)  rd_val = 32'(raw_q & mask_q);
    if (sel_err)  rd_val = 32'(ovf_q) | (32'(unf_q) << 4);
    if (sel_ev)   rd_val = 32'(evsel_q);
    for (int n = 0; n < NSEQ; n++) rd_val = rd_val | win_rd[n];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      mask_q   <= '0;
      evsel_q  <= '0;
      raw_q    <= '0;
      ovf_q    <= '0;
      unf_q    <= '0;
      rdata_q  <= '0;
    end else begin
      if (reg_wr && sel_en)   enable_q <= reg_wdata[NSEQ-1:0];
      if (reg_wr && sel_mask) mask_q   <= reg_wdata[NSEQ-1:0];
      if (reg_wr && sel_ev)   evsel_q  <= reg_wdata[EV_W-1:0];
      raw_q <= raw_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
      if (reg_rd) rdata_q <= rd_val;
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = raw_q & mask_q;

  AST_RAW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q)) != '0) |-> $past(trig)); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ovf_q & ~$past(ovf_q)) != '0) |-> $past(trig)); // R10
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((unf_q & ~$past(unf_q)) != '0) |-> $past(reg_rd)); // R10
endmodule

// File: tb/adc_seq_fifo_top_test.sv
module adc_seq_fifo_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  irq;

  int tests = 0, fails = 0;
  bit done = 0;
  string cur_req = "R7";

  always #10 clk = ~clk;

  adc_seq_fifo_top uut (
    .clk(clk), .rst_n(rst_n), .trig(trig), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  // behavioural reference model
  int          m_q [4][$];
  int          m_rp [4], m_wp [4];
  bit          m_emp [4], m_ful [4];
  logic [31:0] m_noise, m_evs, m_exp;
  logic [31:0] m_mux [4], m_ctl [4];
  logic [3:0]  m_en, m_raw, m_mask, m_ovf, m_unf;
  bit          m_pend;

  function automatic logic [31:0] m_stat(int w);
    return 32'(m_rp[w]) | (32'(m_wp[w]) << 4) | (32'(m_emp[w]) << 8) | (32'(m_ful[w]) << 12);
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    logic [31:0] v = 0;
    int w;
    if (a >= 8'h40 && a < 8'hC0) begin
      w = (int'(a) - 'h40) / 32;
      case (int'(a) % 32)
        0: v = m_mux[w];
        4: v = m_ctl[w];
        8: if (m_emp[w]) begin
             m_unf[w] = 1'b1;
             v = 0;
           end else begin
             v = 32'(m_q[w].pop_front());
             m_rp[w] = (m_rp[w] + 1) % 16;
             m_ful[w] = 0;
             m_emp[w] = (m_rp[w] == m_wp[w]);
           end
        12: v = m_stat(w);
        default: v = 0;
      endcase
    end else begin
      case (a)
        8'h00: v = 32'(m_en);
        8'h04: v = 32'(m_raw);
        8'h08: v = 32'(m_mask);
        8'h0C: v = 32'(m_raw & m_mask);
        8'h10: v = 32'(m_ovf) | (32'(m_unf) << 4);
        8'h14: v = m_evs;
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  function automatic void m_write(logic [7:0] a, logic [31:0] d);
    int w;
    if (a >= 8'h40 && a < 8'hC0) begin
      w = (int'(a) - 'h40) / 32;
      if (int'(a) % 32 == 0) m_mux[w] = d & 32'h3333_3333;
      if (int'(a) % 32 == 4) m_ctl[w] = d;
    end else begin
      case (a)
        8'h00: m_en = d[3:0];
        8'h08: m_mask = d[3:0];
        8'h0C: m_raw = m_raw & ~d[3:0];
        8'h10: begin m_ovf = m_ovf & ~d[3:0]; m_unf = m_unf & ~d[7:4]; end
        8'h14: m_evs = d & 32'h0000_FFFF;
        default: ;
      endcase
    end
  endfunction

  always @(posedge clk) begin
    logic [3:0]  en_old;
    logic [31:0] ev_old;
    if (!rst_n) begin
      for (int w = 0; w < 4; w++) begin
        m_q[w].delete();
        m_rp[w] = 0; m_wp[w] = 0; m_emp[w] = 1; m_ful[w] = 0;
        m_mux[w] = 0; m_ctl[w] = 0;
      end
      m_noise = 0; m_evs = 0; m_en = 0; m_raw = 0; m_mask = 0;
      m_ovf = 0; m_unf = 0; m_pend = 0; m_exp = 0;
    end else begin
      en_old = m_en;
      ev_old = m_evs;
      if (reg_rd) begin m_exp = m_read(reg_addr); m_pend = 1; end
      if (reg_wr) m_write(reg_addr, reg_wdata);
      if (trig) begin
        for (int w = 0; w < 4; w++) begin
          if (en_old[w] && ev_old[4*w +: 4] == 4'd5) begin
            m_noise = m_noise * 32'd314159 + 32'd1;
            m_raw[w] = 1'b1;
            if (m_ful[w]) m_ovf[w] = 1'b1;
            else begin
              m_q[w].push_back('h200 + int'(m_noise[18:16]));
              m_wp[w] = (m_wp[w] + 1) % 16;
              m_emp[w] = 0;
              m_ful[w] = (m_wp[w] == m_rp[w]);
            end
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (irq !== (m_raw & m_mask)) begin
        fails++;
        $display("FAIL R9 irq: actual %h expected %h", irq, m_raw & m_mask);
      end
      if (m_pend) begin
        m_pend = 0;
        tests++;
        if (reg_rdata !== m_exp) begin
          fails++;
          $display("FAIL %s read: actual %h expected %h", cur_req, reg_rdata, m_exp);
        end
      end
    end
  end

  task automatic op(bit w, bit r, bit t, logic [7:0] a, logic [31:0] d, string req);
    @(negedge clk);
    reg_wr = w; reg_rd = r; trig = t; reg_addr = a; reg_wdata = d; cur_req = req;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; trig = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    op(1, 0, 0, a, d, "R7");
  endtask

  task automatic rd(logic [7:0] a, string req);
    op(0, 1, 0, a, 0, req);
  endtask

  task automatic tg();
    op(0, 0, 1, 8'h00, 0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    tests++;
    if (irq !== 4'b0) begin
      fails++;
      $display("FAIL R1 irq after reset: actual %h expected 0", irq);
    end
    for (int w = 0; w < 4; w++) rd(8'(8'h4C + 8'h20 * w), "R1");
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h08, "R1");
    rd(8'h10, "R1"); rd(8'h14, "R1");
    // R7 enable keeps 4 bits, unmapped reads zero
    wr(8'h00, 32'hFF); rd(8'h00, "R7");
    rd(8'h1C, "R7"); rd(8'hE0, "R7");
    // R3 all four sample in one cycle, noise chained
    wr(8'h14, 32'h5555); wr(8'h08, 32'hF); tg();
    rd(8'h0C, "R9");
    for (int w = 0; w < 4; w++) begin
      rd(8'(8'h4C + 8'h20 * w), "R6");
      rd(8'(8'h48 + 8'h20 * w), "R3");
    end
    tg(); tg();
    for (int w = 0; w < 4; w++) rd(8'(8'h48 + 8'h20 * w), "R3");
    // R2 selective triggering
    wr(8'h0C, 32'hF); rd(8'h04, "R9");
    wr(8'h14, 32'h0505); wr(8'h00, 32'h7); tg();
    rd(8'h04, "R2");
    for (int w = 0; w < 4; w++) rd(8'(8'h4C + 8'h20 * w), "R2");
    // R4 fill sequencer 0 past full
    wr(8'h00, 32'h1); wr(8'h14, 32'h5);
    for (int i = 0; i < 18; i++) tg();
    rd(8'h4C, "R4"); rd(8'h10, "R10");
    // R11 pop and trigger together on a full FIFO
    op(0, 1, 1, 8'h48, 0, "R11");
    rd(8'h4C, "R11"); rd(8'h10, "R10");
    // R5 drain and underflow
    for (int i = 0; i < 17; i++) rd(8'h48, "R5");
    rd(8'h4C, "R5"); rd(8'h10, "R10");
    wr(8'h10, 32'hFF); rd(8'h10, "R10");
    // R8 window registers
    wr(8'h60, 32'hFFFF_FFFF); rd(8'h60, "R8");
    wr(8'hA4, 32'hDEAD_BEEF); rd(8'hA4, "R8"); rd(8'h44, "R8");
    // R9 clear and set in the same cycle: set wins
    wr(8'h08, 32'h1);
    op(1, 0, 1, 8'h0C, 32'h1, "R9");
    rd(8'h04, "R9"); rd(8'h0C, "R9");
    // R11 trigger uses enable from before the same-cycle write
    op(1, 0, 1, 8'h00, 32'h0, "R11");
    rd(8'h4C, "R11"); rd(8'h48, "R11");
    tg(); rd(8'h4C, "R2");
    wr(8'h08, 32'h2); rd(8'h0C, "R9");
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule